// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable stand-in for a small serial EEPROM that is reached over a chip-select, serial-clock, data-in and data-out link. A 128-word by 8-bit store is held in flip-flops. The serial pins are brought into the system clock domain through two-flop synchronizers. Serial-clock and chip-select edges are found by comparing each synchronized level with its value one system clock earlier.

A frame opens with a start bit of 1, followed by a two-bit opcode and a seven-bit address, most significant bit first. Opcode 00 uses the two top address bits as a sub-command: enable programming, disable programming, or fill the whole store with one byte. Opcode 01 programs one word and opcode 10 reads one word. Programming commands take effect on the falling edge of chip select after the frame is complete. They then run a self-timed cycle, `PROG_CYC` system clocks long, that needs no serial clock.

After a programming cycle has started, a host that raises chip select again after a long enough deselect sees the busy state on data-out. To clear that indication, the host sends a start bit and then deselects.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, data-out is not driven, programming is disabled and every word of the store reads 0xFF.
- R2: Zero bits clocked while selected, before the first 1, are skipped; that 1 is the start bit. After it come opcode[1:0], then address[6:0], MSB first, each sampled on a serial-clock rising edge.
- R3: Opcode 00 with address[6:5]=11 enables programming and opcode 00 with address[6:5]=00 disables it; both act on the chip-select falling edge.
- R4: Opcode 00 with address[6:5]=01, followed by 8 data bits MSB first, writes that byte into every word once chip select falls. This erases all earlier contents.
- R5: A fill or word write that arrives while programming is disabled has no effect on the store, and no busy status follows it.
- R6: A fill or word-write frame that is deselected before all 8 data bits have arrived changes nothing.
- R7: Opcode 01 with a 7-bit address and 8 data bits, MSB first, programs only that word, once chip select falls, if programming is enabled.
- R8: Opcode 10 with a 7-bit address drives a 0 dummy bit after the last address bit. Each of the next 8 serial-clock rising edges then shifts out the addressed word, MSB first.
- R9: A programming cycle lasts PROG_CYC system clocks from the chip-select falling edge and needs no serial-clock activity.
- R10: After a programming cycle starts, raising chip select after at least TCSL_CYC low clocks drives data-out with status: 0 while busy, 1 when ready. A shorter deselect leaves data-out undriven.
- R11: When the cycle has finished, a start bit followed by chip select falling clears the status indication, and data-out is undriven after the next select.
- R12: Data-out is undriven while chip select is low and while a command frame is being clocked in.
- R13: A frame begun while a programming cycle runs is ignored.
- R14: Opcode 11, and opcode 00 with address[6:5]=10, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data or status out |
| sdo_oe_o | output | 1 | High when sdo_o is driven; low means high impedance |

## Verification
The bench fills the store several times and reads back all 128 words. A fill that wrote one word, or left earlier bytes in place, shows up as a mismatch at a single address. It sends fill and write frames while disabled, while busy and truncated after five data bits. A design that let any of them through would change words that are later read back. It times the busy window against PROG_CYC and checks that a two-clock deselect hides the status while a long deselect shows it. A status that never cleared would appear as a driven data-out after the start-bit-then-deselect sequence.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WEN, CMD_WDS, CMD_FILL, CMD_WORD, CMD_READ
  } cmd_e;

  typedef enum logic [2:0] {
    S_WAIT, S_HDR, S_DATA, S_RDLD, S_READ, S_DONE, S_SKIP
  } rx_state_e;

  // Opcode plus two top address bits select the command.
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sel);
    cmd_e c;
    c = CMD_NONE;
    case (op)
      2'b10: c = CMD_READ;
      2'b01: c = CMD_WORD;
      2'b00: begin
        case (sel)
          2'b11:   c = CMD_WEN;
          2'b00:   c = CMD_WDS;
          2'b01:   c = CMD_FILL;
          default: c = CMD_NONE;
        endcase
      end
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

  function automatic logic cmd_has_data(input cmd_e c);
    return (c == CMD_FILL) || (c == CMD_WORD);
  endfunction

  // Deselect gap long enough for status output.
  function automatic logic gap_met(input int unsigned low_cnt, input int unsigned need);
    return low_cnt >= need;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mwe_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          cs_fall_i,
  input  logic          sck_rise_i,
  input  logic          sdi_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          start_seen_o,
  output logic          rd_en_o,
  output logic          rd_bit_o,
  output logic          wen_set_o,
  output logic          wen_clr_o,
  output logic          fill_go_o,
  output logic          word_go_o
);
  localparam int HW = AW + 2;
  localparam int CW = $clog2(HW + DW + 1);

  rx_state_e      state_q;
  cmd_e           cmd_q;
  logic [CW-1:0]  cnt_q;
  logic [HW-1:0]  hdr_q;
  logic [DW-1:0]  rd_sr_q;

  logic [HW-1:0]  hdr_full;
  cmd_e           hdr_cmd;
  logic           hdr_last, data_last;

  assign hdr_full  = {hdr_q[HW-2:0], sdi_i};
  assign hdr_cmd   = decode_cmd(hdr_full[HW-1:HW-2], hdr_full[AW-1:AW-2]);
  assign hdr_last  = (cnt_q == CW'(HW - 1));
  assign data_last = (cnt_q == CW'(DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_WAIT;
      cmd_q        <= CMD_NONE;
      cnt_q        <= '0;
      hdr_q        <= '0;
      addr_o       <= '0;
      data_o       <= '0;
      rd_sr_q      <= '0;
      rd_bit_o     <= 1'b0;
      rd_en_o      <= 1'b0;
      start_seen_o <= 1'b0;
      wen_set_o    <= 1'b0;
      wen_clr_o    <= 1'b0;
      fill_go_o    <= 1'b0;
      word_go_o    <= 1'b0;
    end else begin
      wen_set_o <= 1'b0;
      wen_clr_o <= 1'b0;
      fill_go_o <= 1'b0;
      word_go_o <= 1'b0;
      if (!cs_i) begin
        state_q      <= S_WAIT;
        start_seen_o <= 1'b0;
        rd_en_o      <= 1'b0;
        rd_bit_o     <= 1'b0;
        cnt_q        <= '0;
        if (cs_fall_i && state_q == S_DONE) begin
          case (cmd_q)
            CMD_WEN:  wen_set_o <= 1'b1;
            CMD_WDS:  wen_clr_o <= 1'b1;
            CMD_FILL: fill_go_o <= 1'b1;
            CMD_WORD: word_go_o <= 1'b1;
            default:  ;
          endcase
        end
      end else if (state_q == S_RDLD) begin
        rd_sr_q  <= rd_data_i;
        rd_bit_o <= 1'b0;
        rd_en_o  <= 1'b1;
        state_q  <= S_READ;
      end else if (sck_rise_i) begin
        case (state_q)
          S_WAIT: begin
            if (sdi_i) begin
              start_seen_o <= 1'b1;
              cnt_q        <= '0;
              state_q      <= busy_i ? S_SKIP : S_HDR;
            end
          end
          S_HDR: begin
            hdr_q <= hdr_full;
            cnt_q <= cnt_q + 1'b1;
            if (hdr_last) begin
              cmd_q  <= hdr_cmd;
              addr_o <= hdr_full[AW-1:0];
              cnt_q  <= '0;
              if (hdr_cmd == CMD_READ)      state_q <= S_RDLD;
              else if (cmd_has_data(hdr_cmd)) state_q <= S_DATA;
              else if (hdr_cmd == CMD_NONE) state_q <= S_SKIP;
              else                          state_q <= S_DONE;
            end
          end
          S_DATA: begin
            data_o <= {data_o[DW-2:0], sdi_i};
            cnt_q  <= cnt_q + 1'b1;
            if (data_last) state_q <= S_DONE;
          end
          S_READ: begin
            rd_bit_o <= rd_sr_q[DW-1];
            rd_sr_q  <= {rd_sr_q[DW-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a frame cut short in its data field never issues a program request
  p_abort_no_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_i && state_q == S_DATA) |=> !(fill_go_o || word_go_o));

  // R13: a start bit seen while busy never leads into header decoding
  p_busy_start_skipped_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && sck_rise_i && sdi_i && busy_i && state_q == S_WAIT) |=> state_q == S_SKIP);

endmodule

// File: rtl/mw_prog_ctrl.sv
module mw_prog_ctrl #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int PROG_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_set_i,
  input  logic          wen_clr_i,
  input  logic          fill_go_i,
  input  logic          word_go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          we_one_o,
  output logic          we_all_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int CW = $clog2(PROG_CYC + 1);

  logic          wen_q;
  logic          all_q;
  logic [CW-1:0] cnt_q;
  logic          finish;

  assign start_o  = (fill_go_i || word_go_i) && wen_q && !busy_o;
  assign finish   = busy_o && (cnt_q == '0);
  assign we_all_o = finish && all_q;
  assign we_one_o = finish && !all_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wen_q <= 1'b0;
    else if (wen_set_i) wen_q <= 1'b1;
    else if (wen_clr_i) wen_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      all_q   <= 1'b0;
      cnt_q   <= '0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else if (start_o) begin
      busy_o  <= 1'b1;
      all_q   <= fill_go_i;
      cnt_q   <= CW'(PROG_CYC - 1);
      waddr_o <= addr_i;
      wdata_o <= data_i;
    end else if (busy_o) begin
      if (finish) busy_o <= 1'b0;
      else        cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R9: the countdown steps by exactly one each busy clock
  p_countdown_steps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(finish)) |-> cnt_q == CW'($past(cnt_q) - 1'b1));

  // R5: a fill request with programming disabled never makes the block busy
  p_fill_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_go_i && !wen_q && !busy_o) |=> !busy_o);

  // R3: an enable command leaves the latch set
  p_enable_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_set_i |=> wen_q);

endmodule

// File: rtl/mw_status.sv
module mw_status
  import mwe_pkg::*;
#(
  parameter int TCSL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic cs_rise_i,
  input  logic cs_fall_i,
  input  logic start_seen_i,
  input  logic busy_i,
  input  logic prog_start_i,
  output logic drive_o,
  output logic level_o
);
  localparam int LW = $clog2(TCSL_CYC + 1);

  logic [LW-1:0] low_cnt_q;
  logic          gap_ok_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      gap_ok_q  <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (cs_i)                             low_cnt_q <= '0;
      else if (low_cnt_q < LW'(TCSL_CYC))   low_cnt_q <= low_cnt_q + 1'b1;

      if (cs_rise_i)      gap_ok_q <= gap_met(32'(low_cnt_q), TCSL_CYC);
      else if (cs_fall_i) gap_ok_q <= 1'b0;

      if (prog_start_i)                                 pend_q <= 1'b1;
      else if (cs_fall_i && start_seen_i && !busy_i)    pend_q <= 1'b0;
    end
  end

  assign drive_o = cs_i && pend_q && gap_ok_q && !start_seen_i;
  assign level_o = !busy_i;

  // R11: the status indication is never dropped while a cycle runs
  p_pending_held_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && busy_i) |=> pend_q);

endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_one_i,
  input  logic          we_all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_all_i || (we_one_i && waddr_i == AW'(i))) mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R4: a fill and a single write are never requested together
  p_one_write_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_all_i && we_one_i));

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mwe_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PROG_CYC    = 64,
  parameter int TCSL_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw, lvl;
  logic             cs_s, sck_s, sdi_s;
  logic             cs_d, sck_d;
  logic             cs_rise, cs_fall, sck_rise;

  assign raw = {sdi_i, sck_i, cs_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw[g]), .q_o(lvl[g])
    );
  end

  assign cs_s  = lvl[0];
  assign sck_s = lvl[1];
  assign sdi_s = lvl[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise  = cs_s && !cs_d;
  assign cs_fall  = !cs_s && cs_d;
  assign sck_rise = sck_s && !sck_d;

  logic [AW-1:0] addr;
  logic [DW-1:0] data, rdata, wdata;
  logic [AW-1:0] waddr;
  logic          start_seen, rd_en, rd_bit;
  logic          wen_set, wen_clr, fill_go, word_go;
  logic          busy, prog_start, we_one, we_all;
  logic          st_drive, st_level;

  mw_frame_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_s), .cs_fall_i(cs_fall),
    .sck_rise_i(sck_rise), .sdi_i(sdi_s), .busy_i(busy), .rd_data_i(rdata),
    .addr_o(addr), .data_o(data), .start_seen_o(start_seen), .rd_en_o(rd_en),
    .rd_bit_o(rd_bit), .wen_set_o(wen_set), .wen_clr_o(wen_clr),
    .fill_go_o(fill_go), .word_go_o(word_go)
  );

  mw_prog_ctrl #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_ni), .wen_set_i(wen_set), .wen_clr_i(wen_clr),
    .fill_go_i(fill_go), .word_go_i(word_go), .addr_i(addr), .data_i(data),
    .busy_o(busy), .start_o(prog_start), .we_one_o(we_one), .we_all_o(we_all),
    .waddr_o(waddr), .wdata_o(wdata)
  );

  mw_status #(.TCSL_CYC(TCSL_CYC)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_s), .cs_rise_i(cs_rise),
    .cs_fall_i(cs_fall), .start_seen_i(start_seen), .busy_i(busy),
    .prog_start_i(prog_start), .drive_o(st_drive), .level_o(st_level)
  );

  mw_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_one_i(we_one), .we_all_i(we_all),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(addr), .rdata_o(rdata)
  );

  assign sdo_o    = st_drive ? st_level : rd_bit;
  assign sdo_oe_o = st_drive || rd_en;

  // R12: data-out is released one clock after chip select goes low
  p_hiz_deselected_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> (cs_s || !sdo_oe_o));

  // R13: no command is committed while a programming cycle runs
  p_busy_blocks_cmds_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(wen_set || wen_clr || fill_go || word_go));

  // R10: anything driven during a busy cycle reads low
  p_busy_reads_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && busy) |-> !sdo_o);

endmodule

// File: tb/mw_eeprom_slave_tb_top.sv
module mw_eeprom_slave_tb_top;
  localparam int PROG = 300;
  localparam int TCSL = 4;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic so_q, oe_q;
  int   checks = 0, errors = 0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  mw_eeprom_slave #(.PROG_CYC(PROG), .TCSL_CYC(TCSL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sdi = b;
    repeat (HP) @(negedge clk);
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    so_q = sdo; oe_q = sdo_oe;
    sck = 1'b0;
  endtask

  task automatic csel();
    cs = 1'b1; repeat (HP) @(negedge clk);
  endtask

  task automatic cdes();
    cs = 1'b0; repeat (10) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [6:0] a,
                            input int nd, input logic [7:0] d, input int lead);
    csel();
    for (int i = 0; i < lead; i++) sbit(1'b0);
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = 6; i >= 0; i--) sbit(a[i]);
    for (int i = 0; i < nd; i++) sbit(d[7-i]);
  endtask

  task automatic wait_prog();
    repeat (PROG + 30) @(negedge clk);
  endtask

  task automatic do_read(input logic [6:0] a, output logic [7:0] d);
    logic hiz;
    csel();
    sbit(1'b1); hiz = !oe_q;
    sbit(1'b1); hiz &= !oe_q;
    sbit(1'b0); hiz &= !oe_q;
    for (int i = 6; i >= 1; i--) begin sbit(a[i]); hiz &= !oe_q; end
    chk(hiz, "R12 header hi-z", 0, 0);
    sbit(a[0]);
    chk(oe_q && !so_q, "R8 dummy zero", {oe_q, so_q}, 2);
    for (int i = 7; i >= 0; i--) begin sbit(1'b0); d[i] = so_q; end
    cdes();
  endtask

  task automatic read_chk(input logic [6:0] a, input string req);
    logic [7:0] d;
    do_read(a, d);
    chk(d == model[a], req, d, model[a]);
  endtask

  task automatic fill_model(input logic [7:0] v);
    for (int i = 0; i < 128; i++) model[i] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill_model(8'hFF);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: undriven output, erased store
    chk(!sdo_oe, "R1 reset oe", sdo_oe, 0);
    read_chk(7'd0, "R1 erased word 0");
    read_chk(7'd77, "R1 erased word 77");
    read_chk(7'd127, "R8 read word 127");

    // R5: fill while disabled
    send_frame(2'b00, 7'b0100110, 8, 8'h3C, 0); cdes();
    csel(); repeat (4) @(negedge clk);
    chk(!sdo_oe, "R5 no status when disabled", sdo_oe, 0);
    cdes(); wait_prog();
    read_chk(7'd0, "R5 store unchanged");
    read_chk(7'd64, "R5 store unchanged");

    // R3 enable, R4 fill, R9/R10 status timing
    send_frame(2'b00, 7'b1101010, 0, 8'h00, 0); cdes();
    send_frame(2'b00, 7'b0111011, 8, 8'hA5, 0);
    cs = 1'b0; repeat (10) @(negedge clk);
    cs = 1'b1; repeat (6) @(negedge clk);
    chk(sdo_oe && !sdo, "R10 busy reads low", {sdo_oe, sdo}, 2);
    repeat (PROG - 36) @(negedge clk);
    chk(sdo_oe && !sdo, "R9 still busy near end", {sdo_oe, sdo}, 2);
    repeat (40) @(negedge clk);
    chk(sdo_oe && sdo, "R9 ready after PROG_CYC", {sdo_oe, sdo}, 3);
    sbit(1'b1); cdes();
    csel(); repeat (4) @(negedge clk);
    chk(!sdo_oe, "R11 status cleared", sdo_oe, 0);
    cdes();
    fill_model(8'hA5);
    for (int i = 0; i < 128; i++) read_chk(7'(i), "R4 fill sweep");

    // R7 single write, R10 short deselect
    send_frame(2'b01, 7'd5, 8, 8'h5A, 0);
    cs = 1'b0; repeat (2) @(negedge clk);
    cs = 1'b1; repeat (6) @(negedge clk);
    chk(!sdo_oe, "R10 short gap hi-z", sdo_oe, 0);
    cs = 1'b0; repeat (10) @(negedge clk);
    cs = 1'b1; repeat (6) @(negedge clk);
    chk(sdo_oe && !sdo, "R10 long gap busy", {sdo_oe, sdo}, 2);
    cs = 1'b0; repeat (2) @(negedge clk);
    chk(!sdo_oe, "R12 cs low hi-z", sdo_oe, 0);
    wait_prog();
    model[5] = 8'h5A;
    read_chk(7'd5, "R7 word written");
    read_chk(7'd4, "R7 neighbour kept");
    read_chk(7'd6, "R7 neighbour kept");

    // R13 commands while busy
    send_frame(2'b00, 7'b0100000, 8, 8'h0F, 0); cdes();
    send_frame(2'b01, 7'd9, 8, 8'h77, 0); cdes();
    send_frame(2'b00, 7'b0000000, 0, 8'h00, 0); cdes();
    wait_prog();
    fill_model(8'h0F);
    read_chk(7'd9, "R13 busy write ignored");
    read_chk(7'd5, "R4 fill erased old word");

    // R6 aborted fill
    send_frame(2'b00, 7'b0100000, 5, 8'h99, 0); cdes();
    csel(); repeat (4) @(negedge clk);
    chk(!sdo_oe, "R6 no cycle after abort", sdo_oe, 0);
    cdes(); wait_prog();
    read_chk(7'd33, "R6 store unchanged");

    // R14 unsupported codes (still enabled, proven by R13 check above)
    send_frame(2'b11, 7'd9, 8, 8'h00, 0); cdes(); wait_prog();
    send_frame(2'b00, 7'b1000000, 8, 8'h00, 0); cdes(); wait_prog();
    read_chk(7'd9, "R14 opcode 11 ignored");
    read_chk(7'd100, "R14 sub-code 10 ignored");

    // R3 disable then enable, R2 leading zeros
    send_frame(2'b00, 7'b0010101, 0, 8'h00, 0); cdes();
    send_frame(2'b01, 7'd9, 8, 8'h44, 0); cdes(); wait_prog();
    read_chk(7'd9, "R3 disabled write ignored");
    send_frame(2'b00, 7'b1100000, 0, 8'h00, 0); cdes();
    send_frame(2'b01, 7'd9, 8, 8'h44, 0); cdes(); wait_prog();
    model[9] = 8'h44;
    read_chk(7'd9, "R3 enabled write");
    send_frame(2'b01, 7'd20, 8, 8'hC3, 3); cdes(); wait_prog();
    model[20] = 8'hC3;
    read_chk(7'd20, "R2 leading zeros skipped");

    for (int i = 0; i < 128; i++) read_chk(7'(i), "R7 final sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule